// File: doc/BRIEF.md
# Banked Memory Protection Region Checker

This block guards memory accesses against a table of up to 32 programmable protection regions. Software fills the table through a small word-addressed register port. The regions are split into two banks of 16, and a bit in the control register chooses which bank the port reaches. Each region has a base register and a permission register. The base register holds a valid flag, the base address and three stored hint bits. The permission register holds a six-bit attribute field and a five-bit size code that is split across two fields.

A purely combinational checker takes an access address, a privilege level and an access kind, and returns grant or deny. It picks the lowest-numbered valid region that contains the address, and that region decides the outcome on its own, whether it grants or denies. When no region contains the address, the default attributes held in the control register apply. When protection is off, every access is granted.

Top module: `prot_region_unit`

## Requirements
- R1: After reset, every register reads 0. Every region is then invalid, protection is off, and bank 0 is selected.
- R2: While control bit 30 (protection on) is 0, `chk_grant` is 1 for every address, privilege and kind.
- R3: Port address 0x00 is the control register: bit 0 selects the bank, bits [8:3] hold the default attributes and bit 30 turns protection on. Addresses 0x40+2n and 0x41+2n reach the permission and base registers of region bank*16+n. Bank 0 and bank 1 hold separate registers, and each reads back the value written to it.
- R4: The size code is {perm[11:9], perm[1:0]}. A region with code c covers the naturally aligned 2^(c+1)-byte block that contains its base. The base bits below the region size are ignored.
- R5: A valid region whose size code is 0 to 3 never matches.
- R6: The attribute bits are ux=bit3, uw=bit4, ur=bit5, kx=bit6, kw=bit7 and kr=bit8. The kind codes are 0=read, 1=write and 2=execute. `chk_kernel` chooses the k bits over the u bits.
- R7: When several valid regions contain the address, the lowest-indexed region alone decides the access, whether it grants or denies.
- R8: With protection on and no matching region, control bits [8:3] decide the access, using the same bit assignment as R6.
- R9: Base-register bits 12, 13 and 14 are hint bits. They are stored and read back, and they have no effect on the check: the base address used for matching has those bits forced to 0. Bits 4:1 of the base register and bit 2 of the permission register read as 0.
- R10: A region whose base-register bit 0 (valid) is 0 never matches. A register write affects the check only from the clock edge that stores it.
- R11: With protection on, kind 3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chk_addr | input | 32 | Address of the access being checked |
| chk_kernel | input | 1 | 1 = kernel privilege, 0 = user |
| chk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| chk_grant | output | 1 | 1 = access allowed |

## Verification
A register write and an access check can occur in the same cycle, and the write can change the outcome of that check. The bench provokes this by raising the write that validates a region while it presents an address that region covers. It expects the check to keep the old deny result until the clock edge that stores the write, and to show the grant just after that edge. The bench also overlaps regions that grant with regions that deny, to confirm that the lower index alone decides in both directions.

// File: rtl/prot_region_unit.sv
module prot_region_unit #(
  parameter int NREG = 32,
  parameter int PER_BANK = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] chk_addr,
  input  logic        chk_kernel,
  input  logic [1:0]  chk_kind,
  output logic        chk_grant
);
  localparam logic [31:0] PERM_KEEP = 32'h0000_0FFB;
  localparam logic [31:0] BASE_KEEP = 32'hFFFF_FFE1;
  localparam logic [31:0] HINT_BITS = 32'h0000_7001;

  logic [31:0] perm_q [NREG];
  logic [31:0] base_q [NREG];
  logic        en_q, bank_q;
  logic [5:0]  dflt_q;

  logic [5:0] widx;
  logic       win_hit;
  assign widx    = {1'b0, bank_q, reg_addr[4:1]};
  assign win_hit = (reg_addr[6:5] == 2'b10) && (int'(widx) < NREG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bank_q <= 1'b0;
      dflt_q <= '0;
      for (int i = 0; i < NREG; i++) begin
        perm_q[i] <= '0;
        base_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == 7'd0) begin
        bank_q <= reg_wdata[0];
        dflt_q <= reg_wdata[8:3];
        en_q   <= reg_wdata[30];
      end else if (win_hit) begin
        if (reg_addr[0]) base_q[widx] <= reg_wdata & BASE_KEEP;
        else             perm_q[widx] <= reg_wdata & PERM_KEEP;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 7'd0)
      reg_rdata = {1'b0, en_q, 21'd0, dflt_q, 2'd0, bank_q};
    else if (win_hit)
      reg_rdata = reg_addr[0] ? base_q[widx] : perm_q[widx];
  end

  logic [NREG-1:0] hit;
  for (genvar g = 0; g < NREG; g++) begin : g_region
    logic [4:0]  code;
    logic [32:0] lim;
    logic [31:0] mask;
    assign code = {perm_q[g][11:9], perm_q[g][1:0]};
    assign lim  = 33'd1 << ({1'b0, code} + 6'd1);
    assign mask = ~(lim[31:0] - 32'd1);
    assign hit[g] = base_q[g][0] && (code >= 5'd4) &&
                    (((chk_addr ^ (base_q[g] & ~HINT_BITS)) & mask) == 32'd0);
  end

  logic [5:0] attr;
  logic       any_hit;
  always_comb begin
    attr    = dflt_q;
    any_hit = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hit[i]) begin
        attr    = perm_q[i][8:3];
        any_hit = 1'b1;
      end
    end
  end

  logic allow;
  always_comb begin
    case (chk_kind)
      2'd0:    allow = chk_kernel ? attr[5] : attr[2];
      2'd1:    allow = chk_kernel ? attr[4] : attr[1];
      2'd2:    allow = chk_kernel ? attr[3] : attr[0];
      default: allow = 1'b0;
    endcase
  end

  assign chk_grant = !en_q || allow;

  p_off_grants_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> chk_grant);

  p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 7'd0) |=> (bank_q == $past(reg_wdata[0]) && en_q == $past(reg_wdata[30])));

  p_default_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !any_hit && chk_kind == 2'd0 && !chk_kernel) |-> (chk_grant == dflt_q[2]));

  p_kind3_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && chk_kind == 2'd3) |-> !chk_grant);
endmodule

// File: tb/tb_prot_region_unit.sv
`timescale 1ns/1ps
module tb_prot_region_unit;
  logic clk = 0, rst_n = 0, reg_we = 0, chk_kernel = 0;
  logic [6:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, chk_addr = 0, reg_rdata;
  logic [1:0] chk_kind = 0;
  logic chk_grant;
  int checks = 0, fails = 0;
  logic [31:0] ctrl_sh = 0;

  prot_region_unit dut (.*);

  always #5 clk = ~clk;

  task automatic wreg(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic expect_v(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input logic [6:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1 expect_v(tag, reg_rdata, exp);
  endtask

  task automatic acc(input logic [31:0] a, input logic k, input logic [1:0] kind,
                     input logic exp, input string tag);
    @(negedge clk); chk_addr = a; chk_kernel = k; chk_kind = kind;
    #1 expect_v(tag, {31'd0, chk_grant}, {31'd0, exp});
  endtask

  task automatic sel_bank(input logic b);
    ctrl_sh[0] = b; wreg(7'h00, ctrl_sh);
  endtask

  task automatic set_region(input int idx, input logic [31:0] base, input logic [4:0] code,
                            input logic [5:0] attr, input logic valid);
    logic [6:0] n;
    n = 7'(idx % 16);
    sel_bank(idx >= 16);
    wreg(7'h40 + 2*n, {20'd0, code[4:2], attr, 1'b0, code[1:0]});
    wreg(7'h41 + 2*n, base | {31'd0, valid});
  endtask

  task automatic t_reset;
    rdchk(7'h00, 32'h0, "R1 ctrl after reset");
    rdchk(7'h47, 32'h0, "R1 base r3 after reset");
    acc(32'h1234_5678, 0, 2'd1, 1, "R2 off grants user write");
    acc(32'hFFFF_FFFF, 1, 2'd3, 1, "R2 off grants kind3");
  endtask

  task automatic t_banks;
    sel_bank(0);
    wreg(7'h44, 32'hFFFF_FFFF); wreg(7'h45, 32'hFFFF_FFFF);
    sel_bank(1);
    wreg(7'h44, 32'h0000_0A5D); wreg(7'h45, 32'h1234_5678);
    rdchk(7'h44, 32'h0000_0A59, "R3 bank1 perm readback");
    rdchk(7'h45, 32'h1234_5660, "R3 R9 bank1 base readback");
    sel_bank(0);
    rdchk(7'h44, 32'h0000_0FFB, "R3 bank0 perm separate");
    rdchk(7'h45, 32'hFFFF_FFE1, "R3 bank0 base separate");
    wreg(7'h44, 0); wreg(7'h45, 0);
    ctrl_sh = 32'h4000_0000; wreg(7'h00, ctrl_sh);
    rdchk(7'h00, 32'h4000_0000, "R3 ctrl readback");
  endtask

  task automatic t_size;
    set_region(5, 32'h0001_0000, 5'd4, 6'b000100, 1);
    acc(32'h0001_001F, 0, 2'd0, 1, "R4 last byte of 32B");
    acc(32'h0001_0020, 0, 2'd0, 0, "R4 past 32B");
    acc(32'h0000_FFFF, 0, 2'd0, 0, "R4 below base");
    set_region(20, 32'h8000_0000, 5'd9, 6'b010000, 1);
    acc(32'h8000_03FF, 1, 2'd1, 1, "R4 R6 1KB kernel write");
    acc(32'h8000_0400, 1, 2'd1, 0, "R4 past 1KB");
    acc(32'h8000_0010, 0, 2'd1, 0, "R6 user write denied");
    acc(32'h8000_0010, 1, 2'd0, 0, "R6 kernel read denied");
  endtask

  task automatic t_priority;
    set_region(3, 32'h0002_0000, 5'd11, 6'h3F, 1);
    set_region(1, 32'h0002_0000, 5'd7, 6'h00, 1);
    acc(32'h0002_0010, 0, 2'd0, 0, "R7 lower deny wins");
    acc(32'h0002_0200, 0, 2'd0, 1, "R7 outer region grants");
    set_region(0, 32'h0002_0000, 5'd4, 6'h3F, 1);
    acc(32'h0002_0010, 0, 2'd0, 1, "R7 lower grant wins");
    acc(32'h0002_0040, 0, 2'd0, 0, "R7 region1 deny again");
  endtask

  task automatic t_reserved;
    set_region(7, 32'h3000_0000, 5'd3, 6'h3F, 1);
    acc(32'h3000_0000, 0, 2'd0, 0, "R5 reserved code no match");
    set_region(7, 32'h3000_0000, 5'd4, 6'h3F, 1);
    acc(32'h3000_0000, 0, 2'd0, 1, "R5 legal code matches");
  endtask

  task automatic t_same_cycle;
    set_region(8, 32'h4000_0000, 5'd4, 6'b000100, 0);
    acc(32'h4000_0004, 0, 2'd0, 0, "R10 invalid region no match");
    @(negedge clk);
    reg_we = 1; reg_addr = 7'h51; reg_wdata = 32'h4000_0001;
    #1 expect_v("R10 write not yet visible", {31'd0, chk_grant}, 32'd0);
    @(posedge clk); #1 reg_we = 0;
    expect_v("R10 write visible after edge", {31'd0, chk_grant}, 32'd1);
  endtask

  task automatic t_hints;
    set_region(9, 32'h6000_7000, 5'd4, 6'h3F, 1);
    rdchk(7'h53, 32'h6000_7001, "R9 hints read back");
    acc(32'h6000_0010, 0, 2'd1, 1, "R9 hints ignored in match");
    acc(32'h6000_7010, 0, 2'd1, 0, "R9 hint bits not address");
    acc(32'h6000_0010, 0, 2'd3, 0, "R11 kind3 denied");
    set_region(10, 32'h7000_0000, 5'd4, 6'b000001, 1);
    acc(32'h7000_0000, 0, 2'd2, 1, "R6 user exec");
    acc(32'h7000_0000, 1, 2'd2, 0, "R6 kernel exec denied");
  endtask

  task automatic t_default;
    acc(32'h5000_0000, 0, 2'd0, 0, "R8 default zero denies");
    ctrl_sh[8:3] = 6'b000100; wreg(7'h00, ctrl_sh);
    acc(32'h5000_0000, 0, 2'd0, 1, "R8 default user read");
    acc(32'h5000_0000, 0, 2'd1, 0, "R8 default user write denied");
    acc(32'h5000_0000, 1, 2'd0, 0, "R8 default kernel read denied");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_banks; t_size; t_priority; t_reserved;
    t_same_cycle; t_hints; t_default;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule